// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block derives two bank clocks from one fast common clock through two integer dividers and produces an active-low warning pulse that falls one period ahead of the next instant at which the rising edges of both banks line up. The warning is meant for system timing that has to know when two related clock domains share an edge. This holds even when neither bank frequency is an integer multiple of the other, as with ratios 3:2, 4:3 or 5:3.

Each bank is driven by a modulo counter over the common clock. A third counter tracks the position inside the least common multiple of the two ratios, which is the length of the coincidence pattern. The warning pulse lasts one period of the faster bank and starts on one of that bank's rising edges. The divide ratios are captured only while reset is held, so a running pattern cannot be disturbed.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst` is high, the 4-bit ratios `ratio_a_in` and `ratio_b_in` are captured after clamping: a value below 2 becomes 2 and a value above 8 becomes 8.
- R2: After reset is released, `bank_a` repeats a period of Na common-clock cycles: it is high for the first ceil(Na/2) cycles and low for the rest. Its first rising edge comes in the first cycle after the first clock edge that samples `rst` low.
- R3: `bank_b` behaves as in R2 with its own ratio Nb and is independent of bank A. Both banks rise together in the first cycle after reset.
- R4: `sync_n` is driven low for exactly Nf common cycles, where Nf = min(Na, Nb) is one period of the faster bank. The low time starts on a rising edge of the faster bank and ends as both banks rise together.
- R5: Both banks rise together every L = lcm(Na, Nb) common cycles counted from the first cycle after reset. The `sync_n` pattern repeats with period L, for integer and non-integer ratios alike.
- R6: While reset is in effect, and in the cycle in which it is first released, `bank_a` and `bank_b` are low and `sync_n` is high.
- R7: Changes on `ratio_a_in` or `ratio_b_in` while `rst` is low have no effect on any output.
- R8: When Na equals Nb, every bank edge is a coincidence, and `sync_n` stays low from the first cycle after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common high-rate clock |
| rst | input | 1 | Synchronous active-high reset; ratios are captured while high |
| ratio_a_in | input | 4 | Divide ratio for bank A |
| ratio_b_in | input | 4 | Divide ratio for bank B |
| bank_a | output | 1 | Divided clock of bank A |
| bank_b | output | 1 | Divided clock of bank B |
| sync_n | output | 1 | Active-low coincidence warning |

## Verification
All three outputs are decoded from registers by combinational logic. Each output is therefore due in the same cycle as the clock edge that updates its counters. The first active cycle is the one after the first edge that samples `rst` low. The bench numbers cycles k = 1, 2, ... from that edge and compares every output at the falling clock edge of cycle k against (k-1) mod N and (k-1) mod L, which it computes itself. Reset cycles are compared at the falling edge of each cycle in which reset is held, and ratio inputs are changed mid-run while the model keeps the captured values.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;

    localparam int RATIO_W   = 4;
    localparam int MIN_RATIO = 2;
    localparam int MAX_RATIO = 8;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam int LCM_MAX   = MAX_RATIO * (MAX_RATIO - 1);
    localparam int LCM_W     = $clog2(LCM_MAX + 1);
    localparam int N_BANKS   = 2;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [LCM_W-1:0]   lcm_t;

    typedef struct packed {
        cnt_t count;
        logic level;
        logic at_edge;
    } bank_state_t;

    typedef struct packed {
        lcm_t   span;
        ratio_t fast;
        logic   a_is_fast;
    } pattern_cfg_t;

    function automatic ratio_t clamp_ratio(input ratio_t r);
        if (r < ratio_t'(MIN_RATIO))      return ratio_t'(MIN_RATIO);
        else if (r > ratio_t'(MAX_RATIO)) return ratio_t'(MAX_RATIO);
        else                              return r;
    endfunction

    function automatic lcm_t lcm_of(input ratio_t a, input ratio_t b);
        lcm_t res;
        logic found;
        res   = lcm_t'(a) * lcm_t'(b);
        found = 1'b0;
        for (int m = 1; m <= MAX_RATIO; m++) begin
            if (!found && ((int'(a) * m) % int'(b) == 0)) begin
                res   = lcm_t'(int'(a) * m);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic pattern_cfg_t make_cfg(input ratio_t a, input ratio_t b);
        pattern_cfg_t c;
        c.span      = lcm_of(a, b);
        c.a_is_fast = (a <= b);
        c.fast      = c.a_is_fast ? a : b;
        return c;
    endfunction

endpackage

// File: rtl/bank_divider.sv
module bank_divider
    import coin_sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  ratio_t      ratio,
    output bank_state_t state
);

    cnt_t   count_q;
    ratio_t high_len;

    assign high_len = (ratio + ratio_t'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (rst || !run)
            count_q <= '0;
        else if (ratio_t'(count_q) == ratio - ratio_t'(1))
            count_q <= '0;
        else
            count_q <= count_q + cnt_t'(1);
    end

    always_comb begin
        state.count   = count_q;
        state.level   = run && (ratio_t'(count_q) < high_len);
        state.at_edge = run && (count_q == '0);
    end

    // R2 R3: counter stays inside its period
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        ratio_t'(count_q) < ratio);

    // R2 R3: counter wraps to zero after the last count
    a_r3_wraps: assert property (@(posedge clk) disable iff (rst)
        (run && ratio_t'(count_q) == ratio - ratio_t'(1)) |=> (count_q == '0));

endmodule

// File: rtl/sync_tracker.sv
module sync_tracker
    import coin_sync_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  pattern_cfg_t cfg,
    input  logic         edge_a,
    input  logic         edge_b,
    output logic         sync_n
);

    lcm_t phase_q;
    logic fast_edge;

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase_q <= '0;
        else if (phase_q == cfg.span - lcm_t'(1))
            phase_q <= '0;
        else
            phase_q <= phase_q + lcm_t'(1);
    end

    assign sync_n    = !(run && (phase_q >= cfg.span - lcm_t'(cfg.fast)));
    assign fast_edge = cfg.a_is_fast ? edge_a : edge_b;

    // R5: pattern start always sees both banks rising
    a_r5_coincide: assert property (@(posedge clk) disable iff (rst)
        (run && phase_q == '0) |-> (edge_a && edge_b));

    // R4: pulse begins on a rising edge of the faster bank
    a_r4_fall_on_fast_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_n) |-> fast_edge);

    // R4: pulse ends exactly as the banks coincide
    a_r4_rise_at_coincidence: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (edge_a && edge_b));

endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
    import coin_sync_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_a_in,
    input  logic [RATIO_W-1:0] ratio_b_in,
    output logic               bank_a,
    output logic               bank_b,
    output logic               sync_n
);

    ratio_t       ratio_in [N_BANKS];
    ratio_t       ratio_q  [N_BANKS];
    bank_state_t  bank_st  [N_BANKS];
    pattern_cfg_t cfg;
    logic         run_q;

    assign ratio_in[0] = ratio_a_in;
    assign ratio_in[1] = ratio_b_in;

    always_ff @(posedge clk) begin
        run_q <= !rst;
    end

    for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                ratio_q[i] <= clamp_ratio(ratio_in[i]);
        end

        bank_divider u_div (
            .clk   (clk),
            .rst   (rst),
            .run   (run_q),
            .ratio (ratio_q[i]),
            .state (bank_st[i])
        );

        // R7: captured ratio does not move while running
        a_r7_ratio_hold: assert property (@(posedge clk) disable iff (rst)
            !rst |=> $stable(ratio_q[i]));
    end

    assign cfg = make_cfg(ratio_q[0], ratio_q[1]);

    sync_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .cfg    (cfg),
        .edge_a (bank_st[0].at_edge),
        .edge_b (bank_st[1].at_edge),
        .sync_n (sync_n)
    );

    assign bank_a = bank_st[0].level;
    assign bank_b = bank_st[1].level;

    // R6: outputs quiet until running
    always_comb begin
        if (!run_q)
            a_r6_reset_quiet: assert (!bank_a && !bank_b && sync_n);
    end

    // R1: captured ratios stay within the supported set
    a_r1_ratio_range: assert property (@(posedge clk) disable iff (rst)
        (ratio_q[0] >= ratio_t'(MIN_RATIO)) && (ratio_q[0] <= ratio_t'(MAX_RATIO)) &&
        (ratio_q[1] >= ratio_t'(MIN_RATIO)) && (ratio_q[1] <= ratio_t'(MAX_RATIO)));

endmodule

// File: tb/coin_sync_gen_bench.sv
`timescale 1ns/1ps
module coin_sync_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ra  = 4'd2;
    logic [3:0] rb  = 4'd2;
    logic       bank_a, bank_b, sync_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    coin_sync_gen u_coin_sync_gen (
        .clk        (clk),
        .rst        (rst),
        .ratio_a_in (ra),
        .ratio_b_in (rb),
        .bank_a     (bank_a),
        .bank_b     (bank_b),
        .sync_n     (sync_n)
    );

    function automatic int clampf(input int r);
        if (r < 2) return 2;
        if (r > 8) return 8;
        return r;
    endfunction

    function automatic int lcmf(input int a, input int b);
        int m = a;
        while (m % b != 0) m += a;
        return m;
    endfunction

    function automatic bit exp_level(input int n, input int k);
        return ((k - 1) % n) < ((n + 1) / 2);
    endfunction

    function automatic bit exp_sync_n(input int na, input int nb, input int k);
        int l  = lcmf(na, nb);
        int nf = (na < nb) ? na : nb;
        return !(((k - 1) % l) >= (l - nf));
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic run_trial(input int a_in, input int b_in, input bit disturb);
        int na = clampf(a_in);
        int nb = clampf(b_in);
        int l  = lcmf(na, nb);
        int cycles = 2 * l + 6;
        string stag;
        @(negedge clk);
        rst = 1'b1;
        ra  = 4'(a_in);
        rb  = 4'(b_in);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6", "bank_a in reset", bank_a, 1'b0);
            check("R6", "bank_b in reset", bank_b, 1'b0);
            check("R6", "sync_n in reset", sync_n, 1'b1);
        end
        rst = 1'b0;
        stag = (na == nb) ? "R8 R4" : "R4 R5";
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            check("R2 R1 R7", "bank_a", bank_a, exp_level(na, k));
            check("R3 R1 R7", "bank_b", bank_b, exp_level(nb, k));
            check(stag, "sync_n", sync_n, exp_sync_n(na, nb, k));
            if (disturb && (k % 5 == 2)) begin
                ra = 4'($urandom_range(0, 15));
                rb = 4'($urandom_range(0, 15));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // directed: non-integer and corner ratios
        run_trial(3, 2, 1'b0);   // R5
        run_trial(4, 3, 1'b0);   // R5
        run_trial(5, 3, 1'b0);   // R5
        run_trial(8, 7, 1'b0);   // R5 longest pattern
        run_trial(2, 4, 1'b0);   // R4 integer multiple
        run_trial(6, 6, 1'b0);   // R8
        run_trial(0, 15, 1'b0);  // R1 clamp both ends
        run_trial(1, 9, 1'b1);   // R1 R7
        run_trial(5, 3, 1'b1);   // R7 disturbance mid-run
        for (int t = 0; t < 30; t++)
            run_trial(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), t[0]);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule